// File: doc/BRIEF.md
# Real-FFT Split Post-Processor

This block turns the output of a 16-point complex FFT into the spectrum of a 32-point real sequence. Upstream, the even-indexed real samples are packed into the real part and the odd-indexed samples into the imaginary part of a 16-point complex vector. That vector is transformed elsewhere, and its 16 complex bins Y(0)..Y(15) are streamed into this block in index order.

Once all 16 bins are held, the block walks k from 0 to 16. For each k it reads the pair Y(k) and Y((16-k) mod 16) and splits them into the spectra of the even and odd subsequences, H(k) = Re_e + j·Im_o and G(k) = Im_e − j·Re_o. It then emits X(k) = H(k) + W32^k·G(k). The twiddle W32^k = cos − j·sin comes from a 13-bit constant table. Bin 16 uses the same datapath with k mod 16 = 0 and W32^16 = −1. The result is 17 real-spectrum bins, one per clock, with their index.

Top module: `rfft_post`

## Requirements
- R1: While reset is held, and afterwards until a full set of 16 input bins has been accepted, `bin_valid` stays low.
- R2: Input bins are accepted only in cycles where `in_valid` is high and the block is collecting. Accepted bins fill indices 0..15 in arrival order. Cycles with `in_valid` low do not advance the index.
- R3: The edge that accepts input index 15 is edge E. Output bin k (k = 0..16) is presented with `bin_valid` high and `bin_idx` = k in the cycle after edge E+1+k. That gives 17 consecutive valid cycles, after which `bin_valid` drops.
- R4: Bin 0 has real part Re(Y0)+Im(Y0) exactly and imaginary part 0.
- R5: Bin 16 has real part Re(Y0)−Im(Y0) exactly and imaginary part 0.
- R6: Bins 1..15 match the 32-point DFT of the original real sequence, X(k) = Σ x(n)·e^(−j2πkn/32), to within 8 LSB on each part.
- R7: Input offered while bins are being emitted, including the cycle in which bin 16 is computed, is ignored. It neither alters the current output nor shifts the next set.
- R8: A new set of input bins may start on the edge at which bin 16 appears, so sets can stream back to back with 17 idle cycles between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bin present |
| in_re | input | DATA_W | Real part of Y(k), signed |
| in_im | input | DATA_W | Imaginary part of Y(k), signed |
| bin_valid | output | 1 | Output bin present |
| bin_idx | output | 5 | Index k of the output bin, 0..16 |
| bin_re | output | DATA_W+2 | Real part of X(k), signed |
| bin_im | output | DATA_W+2 | Imaginary part of X(k), signed |

## Verification
Bin k falls due exactly k+1 cycles after the edge that accepts the sixteenth input bin. The results cannot come sooner, because the pair read and the twiddle multiply-add pass through one register stage. The bench keeps its own cycle model of the collect/emit phases, updated on each rising edge. On every falling edge it compares validity, index and value against that model, so a bin that comes a cycle early or late, or a set that starts one sample off, is caught in the cycle it happens. Expected values come from a floating-point 32-point DFT of the real sequence. Bins 0 and 16 are held to the exact integer sums.

// File: rtl/rfft_post_pkg.sv
package rfft_post_pkg;

    localparam int NC = 16;              // complex FFT length
    localparam int NB = NC + 1;          // output bins 0..NC
    localparam int AW = $clog2(NC);      // input buffer address width
    localparam int KW = $clog2(NB);      // output bin index width
    localparam int TW_BASE_W = 13;       // width the constant table is written for

    typedef struct packed {
        logic          run;
        logic [AW-1:0] wcnt;
        logic [KW-1:0] k;
    } ctl_t;

    // cos(2*pi*i/32) * 2048 for i = 0..8
    function automatic int quarter_cos(input int i);
        case (i)
            0:       return 2048;
            1:       return 2009;
            2:       return 1892;
            3:       return 1703;
            4:       return 1448;
            5:       return 1138;
            6:       return 784;
            7:       return 400;
            default: return 0;
        endcase
    endfunction

    // cos(2*pi*k/32) for k = 0..16
    function automatic int tw_cos(input int k);
        if (k <= NC/2) return quarter_cos(k);
        else           return -quarter_cos(NC - k);
    endfunction

    // sin(2*pi*k/32) for k = 0..16
    function automatic int tw_sin(input int k);
        if (k <= NC/2) return quarter_cos(NC/2 - k);
        else           return quarter_cos(k - NC/2);
    endfunction

endpackage

// File: rtl/rfft_inbuf.sv
module rfft_inbuf #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic signed [DATA_W-1:0] wr_re,
    input  logic signed [DATA_W-1:0] wr_im,
    input  logic [AW-1:0]            rd_a_addr,
    input  logic [AW-1:0]            rd_b_addr,
    output logic signed [DATA_W-1:0] rd_a_re,
    output logic signed [DATA_W-1:0] rd_a_im,
    output logic signed [DATA_W-1:0] rd_b_re,
    output logic signed [DATA_W-1:0] rd_b_im
);

    logic signed [DATA_W-1:0] mem_re_q [DEPTH];
    logic signed [DATA_W-1:0] mem_im_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_re_q[wr_addr] <= wr_re;
            mem_im_q[wr_addr] <= wr_im;
        end
    end

    always_comb begin
        rd_a_re = mem_re_q[rd_a_addr];
        rd_a_im = mem_im_q[rd_a_addr];
        rd_b_re = mem_re_q[rd_b_addr];
        rd_b_im = mem_im_q[rd_b_addr];
    end

endmodule

// File: rtl/rfft_twiddle.sv
module rfft_twiddle
    import rfft_post_pkg::*;
#(
    parameter int COEF_W = 13
) (
    input  logic [KW-1:0]            k,
    output logic signed [COEF_W-1:0] cos_o,
    output logic signed [COEF_W-1:0] sin_o
);

    localparam int SHIFT = COEF_W - TW_BASE_W;

    always_comb begin
        cos_o = COEF_W'(tw_cos(int'(k)) <<< SHIFT);
        sin_o = COEF_W'(tw_sin(int'(k)) <<< SHIFT);
    end

endmodule

// File: rtl/rfft_butterfly.sv
module rfft_butterfly
    import rfft_post_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 13,
    localparam int OUT_W = DATA_W + 2,
    localparam int SUM_W = DATA_W + 1,
    localparam int ACC_W = SUM_W + COEF_W + 2,
    localparam int FRAC  = COEF_W - 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_v,
    input  logic [KW-1:0]            in_idx,
    input  logic signed [DATA_W-1:0] a_re,
    input  logic signed [DATA_W-1:0] a_im,
    input  logic signed [DATA_W-1:0] b_re,
    input  logic signed [DATA_W-1:0] b_im,
    input  logic signed [COEF_W-1:0] tw_c,
    input  logic signed [COEF_W-1:0] tw_s,
    output logic                     out_v,
    output logic [KW-1:0]            out_idx,
    output logic signed [OUT_W-1:0]  out_re,
    output logic signed [OUT_W-1:0]  out_im
);

    typedef struct packed {
        logic                    v;
        logic [KW-1:0]           idx;
        logic signed [OUT_W-1:0] re;
        logic signed [OUT_W-1:0] im;
    } bout_t;

    bout_t d, q;

    logic signed [SUM_W-1:0] s_rr, d_rr, s_ii, d_ii;
    logic signed [ACC_W-1:0] acc_re, acc_im;

    always_comb begin
        // twice the even/odd components
        s_rr = SUM_W'(a_re) + SUM_W'(b_re);
        d_rr = SUM_W'(a_re) - SUM_W'(b_re);
        s_ii = SUM_W'(a_im) + SUM_W'(b_im);
        d_ii = SUM_W'(a_im) - SUM_W'(b_im);
        // 2*X scaled by 2^FRAC
        acc_re = (ACC_W'(s_rr) <<< FRAC)
               + ACC_W'(tw_c) * ACC_W'(s_ii)
               - ACC_W'(tw_s) * ACC_W'(d_rr);
        acc_im = (ACC_W'(d_ii) <<< FRAC)
               - ACC_W'(tw_c) * ACC_W'(d_rr)
               - ACC_W'(tw_s) * ACC_W'(s_ii);
        d     = q;
        d.v   = in_v;
        if (in_v) begin
            d.idx = in_idx;
            d.re  = OUT_W'(acc_re >>> (FRAC + 1));
            d.im  = OUT_W'(acc_im >>> (FRAC + 1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_v   = q.v;
    assign out_idx = q.idx;
    assign out_re  = q.re;
    assign out_im  = q.im;

    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_v && out_idx != KW'(NC)) |=> (out_v && out_idx == $past(out_idx) + KW'(1)));

    // R4 R5
    edge_bins_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_v && (out_idx == '0 || out_idx == KW'(NC))) |-> (out_im == '0));

endmodule

// File: rtl/rfft_post.sv
module rfft_post
    import rfft_post_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 13,
    localparam int OUT_W = DATA_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_re,
    input  logic signed [DATA_W-1:0] in_im,
    output logic                     bin_valid,
    output logic [KW-1:0]            bin_idx,
    output logic signed [OUT_W-1:0]  bin_re,
    output logic signed [OUT_W-1:0]  bin_im
);

    ctl_t d, q;
    logic wr_en;

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        if (!q.run) begin
            if (in_valid) begin
                wr_en  = 1'b1;
                d.wcnt = q.wcnt + AW'(1);
                if (q.wcnt == AW'(NC - 1)) begin
                    d.run = 1'b1;
                    d.k   = '0;
                end
            end
        end else begin
            if (q.k == KW'(NC)) begin
                d.run = 1'b0;
                d.k   = '0;
            end else begin
                d.k = q.k + KW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic [AW-1:0] a_addr, b_addr;
    logic signed [DATA_W-1:0] a_re, a_im, b_re, b_im;
    logic signed [COEF_W-1:0] tw_c, tw_s;

    assign a_addr = q.k[AW-1:0];
    assign b_addr = -a_addr;

    rfft_inbuf #(.DATA_W(DATA_W), .DEPTH(NC)) u_buf (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (q.wcnt),
        .wr_re     (in_re),
        .wr_im     (in_im),
        .rd_a_addr (a_addr),
        .rd_b_addr (b_addr),
        .rd_a_re   (a_re),
        .rd_a_im   (a_im),
        .rd_b_re   (b_re),
        .rd_b_im   (b_im)
    );

    rfft_twiddle #(.COEF_W(COEF_W)) u_tw (
        .k     (q.k),
        .cos_o (tw_c),
        .sin_o (tw_s)
    );

    rfft_butterfly #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_bf (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_v    (q.run),
        .in_idx  (q.k),
        .a_re    (a_re),
        .a_im    (a_im),
        .b_re    (b_re),
        .b_im    (b_im),
        .tw_c    (tw_c),
        .tw_s    (tw_s),
        .out_v   (bin_valid),
        .out_idx (bin_idx),
        .out_re  (bin_re),
        .out_im  (bin_im)
    );

    // R3
    first_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bin_valid) |-> (bin_idx == '0));

    // R3
    last_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bin_valid && bin_idx == KW'(NC)) |=> !bin_valid);

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.run |=> (q.wcnt == '0));

    // R2
    collect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.run && !$past(q.run)) |-> !bin_valid);

endmodule

// File: tb/tb_rfft_post.sv
module tb_rfft_post;

    localparam int DATA_W = 16;
    localparam int OUT_W  = DATA_W + 2;
    localparam real TOL   = 8.0;
    localparam real PI    = 3.14159265358979;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic signed [DATA_W-1:0] in_re = '0;
    logic signed [DATA_W-1:0] in_im = '0;
    logic                    bin_valid;
    logic [4:0]              bin_idx;
    logic signed [OUT_W-1:0] bin_re;
    logic signed [OUT_W-1:0] bin_im;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    rfft_post #(.DATA_W(DATA_W), .COEF_W(13)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .bin_valid(bin_valid), .bin_idx(bin_idx), .bin_re(bin_re), .bin_im(bin_im)
    );

    // stimulus state
    int  xcur [32];
    int  ycr  [16];
    int  yci  [16];

    // reference model state
    bit  m_run = 0;
    int  m_cnt = 0;
    int  m_k   = 0;
    bit  e_v   = 0;
    int  e_k   = 0;
    int  m_yr  [16];
    int  m_yi  [16];
    real e_re  [17];
    real e_im  [17];

    function automatic int rnd(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        else          return -$rtoi(-v + 0.5);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic chk_r(input string tag, input int act, input real exp);
        real diff;
        diff = $itor(act) - exp;
        if (diff < 0.0) diff = -diff;
        total++;
        if (diff > TOL) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0f (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // reference model: advances on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_k = 0; e_v = 0;
        end else begin
            e_v = 0;
            if (m_run) begin
                e_v = 1; e_k = m_k; m_k++;
                if (m_k == 17) m_run = 0;
            end else if (in_valid) begin
                m_yr[m_cnt] = int'(in_re);
                m_yi[m_cnt] = int'(in_im);
                m_cnt++;
                if (m_cnt == 16) begin
                    m_cnt = 0; m_run = 1; m_k = 0;
                    for (int k = 0; k < 17; k++) begin
                        real sr, si;
                        sr = 0.0; si = 0.0;
                        for (int n = 0; n < 32; n++) begin
                            sr += $itor(xcur[n]) * $cos(2.0 * PI * k * n / 32.0);
                            si -= $itor(xcur[n]) * $sin(2.0 * PI * k * n / 32.0);
                        end
                        e_re[k] = sr; e_im[k] = si;
                    end
                end
            end
        end
    end

    // comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done && (e_v || bin_valid)) begin
            chk(bin_valid == e_v, "R3 valid timing", bin_valid, e_v);
            if (e_v && bin_valid) begin
                chk(int'(bin_idx) == e_k, "R3 bin index", bin_idx, e_k);
                if (e_k == 0) begin
                    chk(int'(bin_re) == m_yr[0] + m_yi[0], "R4 bin0 re", bin_re, m_yr[0] + m_yi[0]);
                    chk(bin_im == 0, "R4 bin0 im", bin_im, 0);
                end else if (e_k == 16) begin
                    chk(int'(bin_re) == m_yr[0] - m_yi[0], "R5 bin16 re", bin_re, m_yr[0] - m_yi[0]);
                    chk(bin_im == 0, "R5 bin16 im", bin_im, 0);
                end else begin
                    chk_r("R6 bin re", int'(bin_re), e_re[e_k]);
                    chk_r("R6 bin im", int'(bin_im), e_im[e_k]);
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic fill_x(input int pat);
        for (int n = 0; n < 32; n++) begin
            case (pat)
                0:       xcur[n] = (n == 0) ? 700 : 0;
                1:       xcur[n] = 500;
                2:       xcur[n] = (n % 2 == 0) ? 600 : -600;
                3:       xcur[n] = rnd(600.0 * $cos(2.0 * PI * 5.0 * n / 32.0));
                4:       xcur[n] = (n == 31) ? -700 : 0;
                default: xcur[n] = int'($urandom % 1401) - 700;
            endcase
        end
        for (int k = 0; k < 16; k++) begin
            real yr, yi;
            yr = 0.0; yi = 0.0;
            for (int n = 0; n < 16; n++) begin
                real c, s;
                c = $cos(2.0 * PI * k * n / 16.0);
                s = $sin(2.0 * PI * k * n / 16.0);
                yr += $itor(xcur[2*n]) * c + $itor(xcur[2*n+1]) * s;
                yi += $itor(xcur[2*n+1]) * c - $itor(xcur[2*n]) * s;
            end
            ycr[k] = rnd(yr); yci[k] = rnd(yi);
        end
    endtask

    // R2 R8 gaps inside a set; R7 junk during emission
    task automatic send_set(input int pat, input bit gaps, input bit junk);
        fill_x(pat);
        for (int i = 0; i < 16; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_re = DATA_W'($urandom); in_im = DATA_W'($urandom);
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_re = DATA_W'(ycr[i]); in_im = DATA_W'(yci[i]);
        end
        for (int j = 0; j < 17; j++) begin
            @(negedge clk);
            in_valid = junk;
            in_re = DATA_W'($urandom); in_im = DATA_W'($urandom);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: quiet during reset
        chk(bin_valid == 1'b0, "R1 reset valid", bin_valid, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(bin_valid == 1'b0, "R1 idle after reset", bin_valid, 0);
        send_set(0, 0, 0);
        send_set(1, 0, 1);
        send_set(2, 1, 0);
        send_set(3, 0, 1);
        send_set(4, 0, 0);
        send_set(5, 1, 1);
        send_set(6, 0, 1);
        send_set(7, 0, 0);
        // R1: a partial set of 15 gives nothing
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_re = DATA_W'(i); in_im = '0;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk(bin_valid == 1'b0, "R1 partial set no output", bin_valid, 0);
        repeat (5) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule